// File: doc/BRIEF.md
# Dual-Rate Overrange Monitor

This block watches the signed sample stream coming out of the first decimation stage of a sigma-delta converter. It checks each sample's magnitude against a programmable threshold and reports the result in two ways. The live alert output tracks the comparison on every first-stage sample. It goes high on a sample above the threshold and drops again on the first sample that is not above it.

The per-word status bit changes more slowly. Between two output-word strobes, an internal sticky flag records whether any sample exceeded the threshold. At each strobe that flag is copied into the status bit and then cleared, so the status bit describes exactly one conversion window. The first-stage rate is 16, 32 or 64 times the output word rate. The block does not need to know which ratio applies, because it counts nothing and simply uses the strobe. Downstream logic places the status bit in the serial output word as bit D6 and mirrors it into a readable status register.

The threshold is held in a register with a simple write port. After reset it holds 80% of the full-scale positive code.

Top module: `ovr_monitor`

## Requirements
- R1: While reset is asserted, and after it is released until the first sample or strobe, both `alert` and `word_ovr` are 0.
- R2: In the clock cycle after a cycle with `smp_valid` high, `alert` is 1 if the sample magnitude is strictly greater than the threshold, and 0 otherwise.
- R3: `alert` keeps its value through cycles in which `smp_valid` is low.
- R4: A sample whose magnitude equals the threshold exactly is not an overrange, for both the alert and the status bit.
- R5: Magnitude is the absolute value of the two's-complement `smp_data`. The most negative code (MSB 1, all other bits 0) saturates to the largest positive code, 2^(SAMPLE_W-1)-1.
- R6: In the cycle after `word_strobe` is high, `word_ovr` is 1 if and only if some valid sample exceeded the threshold since the previous strobe. A valid sample in the strobe cycle itself belongs to the window being closed.
- R7: The sticky window flag clears at each strobe. A window with no exceeding sample reports 0 at its strobe, even if the previous window reported 1.
- R8: After reset the threshold is floor((2^(SAMPLE_W-1)-1)*4/5). With SAMPLE_W=16 that is 26213: a magnitude of 26213 is not an overrange and 26214 is.
- R9: A write with `lim_wr_en` high loads `lim_wr_data` into the threshold. It applies to samples from the next cycle on. A sample presented in the same cycle as the write is compared against the old threshold.
- R10: `word_ovr` changes only in the cycle after a `word_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | First-stage sample strobe |
| smp_data | input | SAMPLE_W | Signed two's-complement first-stage sample |
| word_strobe | input | 1 | Output-word strobe, one pulse per conversion result |
| lim_wr_en | input | 1 | Threshold write enable |
| lim_wr_data | input | SAMPLE_W-1 | New unsigned threshold value |
| alert | output | 1 | Live overrange alert at the first-stage rate |
| word_ovr | output | 1 | Overrange status of the last completed output word |

## Verification
The bench targets the following corner cases. A sample exactly at the threshold would raise a false alert in a design that compares with greater-or-equal. The most negative code would read as a tiny magnitude, or as zero, if its negation wrapped. A sample arriving in the same cycle as the word strobe would be lost from its window, or leak into the next one, if the clear and the latch were ordered wrongly. A window with no overrange that follows a window with one would still report 1 if the sticky flag never cleared. The bench also writes the threshold in the same cycle as a sample, which shows whether the write takes effect early, and leaves idle gaps between samples, which would expose an alert that decays or a status bit that moves without a strobe.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

  // Threshold reset value: four fifths of the largest positive magnitude code.
  function automatic longint def_limit(input int mag_w);
    longint full;
    full = (longint'(1) <<< mag_w) - 1;
    return (full * 4) / 5;
  endfunction

endpackage

// File: rtl/ovr_mag.sv
module ovr_mag #(
  parameter int SAMPLE_W = 16,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input  logic [SAMPLE_W-1:0] din,
  output logic [MAG_W-1:0]    mag
);

  logic [SAMPLE_W-1:0] negated;

  always_comb begin
    negated = ~din + {{(SAMPLE_W-1){1'b0}}, 1'b1};
    if (!din[SAMPLE_W-1]) begin
      mag = din[MAG_W-1:0];
    end else if (negated[SAMPLE_W-1]) begin
      // only the most negative code stays negative after negation
      mag = {MAG_W{1'b1}};
    end else begin
      mag = negated[MAG_W-1:0];
    end
  end

endmodule

// File: rtl/ovr_limit.sv
module ovr_limit #(
  parameter int MAG_W = 15,
  parameter logic [MAG_W-1:0] LIM_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MAG_W-1:0] wr_data,
  output logic [MAG_W-1:0] limit
);

  logic [MAG_W-1:0] lim_d;
  logic [MAG_W-1:0] lim_q;

  always_comb begin
    lim_d = lim_q;
    if (wr_en) lim_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lim_q <= LIM_RST;
    else        lim_q <= lim_d;
  end

  assign limit = lim_q;

endmodule

// File: rtl/ovr_flags.sv
module ovr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic over,
  input  logic word_strobe,
  output logic alert,
  output logic word_ovr
);

  logic alert_q, alert_d;
  logic sticky_q, sticky_d;
  logic word_q, word_d;
  logic hit;

  assign hit = smp_valid & over;

  always_comb begin
    alert_d  = alert_q;
    sticky_d = sticky_q;
    word_d   = word_q;
    if (smp_valid) alert_d = over;
    if (word_strobe) begin
      // a sample in the strobe cycle closes into the current window
      word_d   = sticky_q | hit;
      sticky_d = 1'b0;
    end else if (hit) begin
      sticky_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q  <= 1'b0;
      sticky_q <= 1'b0;
      word_q   <= 1'b0;
    end else begin
      alert_q  <= alert_d;
      sticky_q <= sticky_d;
      word_q   <= word_d;
    end
  end

  assign alert    = alert_q;
  assign word_ovr = word_q;

endmodule

// File: rtl/ovr_monitor.sv
module ovr_monitor #(
  parameter int SAMPLE_W = 16,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                word_strobe,
  input  logic                lim_wr_en,
  input  logic [MAG_W-1:0]    lim_wr_data,
  output logic                alert,
  output logic                word_ovr
);

  localparam logic [MAG_W-1:0] LIM_RST = MAG_W'(ovr_pkg::def_limit(MAG_W));

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] lim_q;
  logic             over;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ovr_mag #(.SAMPLE_W(SAMPLE_W)) u_mag (
    .din (smp_data),
    .mag (mag)
  );

  ovr_limit #(.MAG_W(MAG_W), .LIM_RST(LIM_RST)) u_lim (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (lim_wr_en),
    .wr_data (lim_wr_data),
    .limit   (lim_q)
  );

  assign over = (mag > lim_q);

  ovr_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .smp_valid   (smp_valid),
    .over        (over),
    .word_strobe (word_strobe),
    .alert       (alert),
    .word_ovr    (word_ovr)
  );

endmodule

// File: rtl/ovr_monitor_chk.sv
module ovr_monitor_chk #(
  parameter int SAMPLE_W = 16,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic                word_strobe,
  input logic [MAG_W-1:0]    limit,
  input logic                alert,
  input logic                word_ovr
);

  logic [SAMPLE_W:0] chk_abs;
  logic              chk_over;

  always_comb begin
    if (smp_data[SAMPLE_W-1]) chk_abs = {1'b0, (~smp_data)} + 1'b1;
    else                      chk_abs = {1'b0, smp_data};
    if (chk_abs[SAMPLE_W-1:0] == {1'b1, {(SAMPLE_W-1){1'b0}}})
      chk_abs = {2'b00, {MAG_W{1'b1}}};
    chk_over = chk_abs > {2'b00, limit};
  end

  AST_ALERT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && chk_over) |=> alert); // R2
  AST_ALERT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !chk_over) |=> !alert); // R4
  AST_ALERT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(alert)); // R3
  AST_WORD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_strobe && smp_valid && chk_over) |=> word_ovr); // R6
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_strobe |=> $stable(word_ovr)); // R10

endmodule

bind ovr_monitor ovr_monitor_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .smp_valid   (smp_valid),
  .smp_data    (smp_data),
  .word_strobe (word_strobe),
  .limit       (lim_q),
  .alert       (alert),
  .word_ovr    (word_ovr)
);

// File: tb/tb_ovr_monitor.sv
module tb_ovr_monitor;

  localparam int W  = 16;
  localparam int MW = W - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [W-1:0]  smp_data = '0;
  logic          word_strobe = 1'b0;
  logic          lim_wr_en = 1'b0;
  logic [MW-1:0] lim_wr_data = '0;
  logic          alert, word_ovr;

  always #2 clk = ~clk;

  ovr_monitor #(.SAMPLE_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .word_strobe(word_strobe), .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data),
    .alert(alert), .word_ovr(word_ovr)
  );

  typedef struct {
    logic  exp_alert;
    logic  exp_word;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  // reference model state
  int   m_lim = 26213;
  bit   m_acc = 0;
  bit   m_alert = 0;
  bit   m_word = 0;

  function automatic int abs_sat(input logic [W-1:0] d);
    int v;
    v = $signed(d);
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    return v;
  endfunction

  task automatic step(input bit v, input int val, input bit strb,
                      input bit wr, input int wval, input string tag);
    exp_t e;
    bit   ex;
    @(negedge clk);
    smp_valid   = v;
    smp_data    = W'(val);
    word_strobe = strb;
    lim_wr_en   = wr;
    lim_wr_data = MW'(wval);
    ex = v && (abs_sat(W'(val)) > m_lim);
    if (v) m_alert = ex;
    if (strb) begin
      m_word = m_acc | ex;
      m_acc  = 0;
    end else if (ex) begin
      m_acc = 1;
    end
    if (wr) m_lim = wval;
    e.exp_alert = m_alert;
    e.exp_word  = m_word;
    e.tag       = tag;
    q.push_back(e);
  endtask

  // monitor: compares one expected item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (alert !== e.exp_alert) begin
          n_fail++;
          $display("FAIL %s alert: actual %b expected %b", e.tag, alert, e.exp_alert);
        end
        n_run++;
        if (word_ovr !== e.exp_word) begin
          n_fail++;
          $display("FAIL %s word_ovr: actual %b expected %b", e.tag, word_ovr, e.exp_word);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 during reset
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (alert !== 1'b0 || word_ovr !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: actual %b%b expected 00", alert, word_ovr);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_run++;
    if (alert !== 1'b0 || word_ovr !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after release: actual %b%b expected 00", alert, word_ovr);
    end

    // default threshold boundary
    step(1, 26213, 0, 0, 0, "R8_R4 at default limit");
    step(1, 26214, 0, 0, 0, "R8_R2 above default limit");
    step(0, 0,     0, 0, 0, "R3 idle hold");
    step(0, 5,     0, 0, 0, "R3 idle hold 2");
    step(1, 100,   0, 0, 0, "R2 small sample drops alert");
    step(0, 30000, 0, 0, 0, "R3 invalid large ignored");
    step(1, -26214, 0, 0, 0, "R5 negative over");
    step(1, -26213, 0, 0, 0, "R5_R4 negative equal");
    step(1, -32768, 0, 0, 0, "R5 most negative");
    step(1, 7,     0, 0, 0, "R2 small");
    // window closes with earlier hits
    step(0, 0,     1, 0, 0, "R6 strobe after hits");
    step(1, 20,    0, 0, 0, "R10 hold");
    step(1, -20,   0, 0, 0, "R10 hold 2");
    step(0, 0,     1, 0, 0, "R7 clean window");
    // hit in the strobe cycle itself
    step(1, 1,     0, 0, 0, "R7 pre");
    step(1, 30000, 1, 0, 0, "R6 hit on strobe");
    step(1, 2,     0, 0, 0, "R10 after strobe");
    step(0, 0,     1, 0, 0, "R7 clears after strobe hit");
    // limit write
    step(1, 2000,  0, 1, 1000, "R9 write same cycle old limit");
    step(1, 2000,  0, 0, 0, "R9 new limit applies");
    step(1, 1000,  0, 0, 0, "R4 equal new limit");
    step(1, -1000, 0, 0, 0, "R4_R5 negative equal");
    step(1, -1001, 0, 0, 0, "R5 negative over new limit");
    step(0, 0,     1, 0, 0, "R6 window with hits");
    step(1, 0,     0, 1, 32767, "R9 write max");
    step(1, -32768, 0, 0, 0, "R5 most negative equals max");
    step(1, 32767, 0, 0, 0, "R4 max equal");
    step(0, 0,     1, 0, 0, "R7 clean at max limit");
    step(0, 0,     0, 0, 0, "R10 idle");
    step(0, 0,     0, 0, 0, "R10 idle 2");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule